// File: doc/BRIEF.md
# Lease Countdown Timer with LFSR Second Prescaler

This block keeps track of how many seconds remain on an address lease granted by a network configuration server. When software or a protocol engine loads a lease length in seconds, the block restarts its timing. It then counts the remaining seconds down once per second of the system clock. It raises a near-expiry flag when the time left falls to a chosen fraction of the loaded lease, which is the point to start a renewal. It raises an expired flag when the count reaches zero.

The sub-second prescaler is a maximal-length Galois LFSR, not a binary counter. It starts from a fixed non-zero seed. At elaboration time the block computes the LFSR state that lies exactly `CYCLES_PER_SEC - 1` steps after the seed. When the register reaches that state, one second has passed and the seed is loaded again. A plain binary down-counter holds the seconds. The loaded lease is clamped to a one-day ceiling, so the counter needs only 17 bits. A stop input freezes all timing, for example while the link is down.

Top module: `lease_timer`

## Requirements
- R1: After reset `secs_left` is 0 and both `near_exp` and `expired` are 0.
- R2: A `load` pulse sets `secs_left` on the following clock to `lease_s`, or to `MAX_LEASE` (86400) when `lease_s` is larger.
- R3: After a load, `secs_left` drops by exactly one every `CYCLES_PER_SEC` clocks (100,000,000 by default). The first drop happens `CYCLES_PER_SEC` clocks after the load edge.
- R4: `expired` is 1 while an active count is at 0, and the count then holds at 0.
- R5: `near_exp` is 1 while `secs_left` is no more than the clamped lease shifted right by `thr_sel + 1`. So `thr_sel` 0 gives one half, 1 one quarter, 2 one eighth and 3 one sixteenth. `thr_sel` is sampled at load.
- R6: While `stop` is 1, both `secs_left` and the sub-second phase are frozen and both flags read 0. When `stop` is released, counting resumes from the frozen phase.
- R7: A load in the middle of a count restarts both the seconds and the sub-second phase, so a full second elapses before the next drop.
- R8: A load that coincides with a second boundary takes priority: the new value is not decremented in that cycle.
- R9: Loading a lease of 0 gives `expired` on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| load | input | 1 | Start a new lease countdown |
| lease_s | input | 32 | Lease length in seconds, sampled on load |
| thr_sel | input | 2 | Renewal threshold as a right shift of the lease (0 half … 3 sixteenth) |
| stop | input | 1 | Freeze timing and clear the flags |
| near_exp | output | 1 | Remaining time is at or below the renewal threshold |
| expired | output | 1 | Remaining time has reached zero |
| secs_left | output | 17 | Seconds remaining |

## Verification
A new load can arrive in the same cycle in which the prescaler flags a second boundary. The bench provokes this by running one clock short of a full second after a load and then pulsing load again. At that point the LFSR sits on its terminal state. The bench judges the result by checking that the new value appears undecremented. It also checks that the next drop comes a full second later, which shows the prescaler was reseeded rather than allowed to wrap.

// File: rtl/lease_timer_pkg.sv
package lease_timer_pkg;

    typedef enum logic [1:0] {
        THR_HALF      = 2'd0,
        THR_QUARTER   = 2'd1,
        THR_EIGHTH    = 2'd2,
        THR_SIXTEENTH = 2'd3
    } thr_sel_e;

    localparam int DEF_CYCLES_PER_SEC = 100_000_000;
    localparam int DEF_MAX_LEASE      = 86_400;
    localparam int DEF_LFSR_W         = 27;

    // Saturate a 32-bit lease to the ceiling
    function automatic logic [31:0] clamp_lease(input logic [31:0] v, input logic [31:0] cap);
        return (v > cap) ? cap : v;
    endfunction

endpackage

// File: rtl/lease_lfsr_prescaler.sv
module lease_lfsr_prescaler #(
    parameter int              LFSR_W         = 27,
    parameter logic [LFSR_W-1:0] POLY_LOW     = 27'h27,
    parameter logic [LFSR_W-1:0] SEED         = 27'h1,
    parameter int              CYCLES_PER_SEC = 100_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic run,
    output logic tick
);

    // multiply state polynomial by x modulo the feedback polynomial
    function automatic logic [LFSR_W-1:0] xtime(input logic [LFSR_W-1:0] s);
        logic [LFSR_W-1:0] r;
        r = {s[LFSR_W-2:0], 1'b0};
        if (s[LFSR_W-1]) r = r ^ POLY_LOW;
        return r;
    endfunction

    function automatic logic [LFSR_W-1:0] mulmod(input logic [LFSR_W-1:0] a,
                                                 input logic [LFSR_W-1:0] b);
        logic [LFSR_W-1:0] r;
        r = '0;
        for (int i = LFSR_W - 1; i >= 0; i--) begin
            r = xtime(r);
            if (b[i]) r = r ^ a;
        end
        return r;
    endfunction

    // state reached after n steps from SEED, by square-and-multiply on x^n
    function automatic logic [LFSR_W-1:0] jump_state(input logic [31:0] n);
        logic [LFSR_W-1:0] acc;
        logic [LFSR_W-1:0] base;
        acc  = {{(LFSR_W-1){1'b0}}, 1'b1};
        base = {{(LFSR_W-2){1'b0}}, 2'b10};
        for (int i = 0; i < 32; i++) begin
            if (n[i]) acc = mulmod(acc, base);
            base = mulmod(base, base);
        end
        return mulmod(SEED, acc);
    endfunction

    localparam logic [31:0]       STEPS_TO_TERM = 32'(CYCLES_PER_SEC - 1);
    localparam logic [LFSR_W-1:0] TERM_STATE    = jump_state(STEPS_TO_TERM);

    typedef struct packed {
        logic [LFSR_W-1:0] lfsr;
    } pre_state_t;

    pre_state_t st_d, st_q;
    logic       at_term;

    always_comb begin
        st_d    = st_q;
        at_term = (st_q.lfsr == TERM_STATE);
        if (restart) begin
            st_d.lfsr = SEED;
        end else if (run) begin
            st_d.lfsr = at_term ? SEED : xtime(st_q.lfsr);
        end
    end

    assign tick = run && at_term && !restart;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{lfsr: SEED};
        else        st_q <= st_d;
    end

endmodule

// File: rtl/lease_seconds_counter.sv
module lease_seconds_counter
    import lease_timer_pkg::*;
#(
    parameter int MAX_LEASE = 86_400,
    parameter int SEC_W     = 17
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [31:0]      lease_s,
    input  thr_sel_e         thr_sel,
    input  logic             tick,
    output logic [SEC_W-1:0] secs,
    output logic [SEC_W-1:0] thr,
    output logic             active
);

    typedef struct packed {
        logic [SEC_W-1:0] secs;
        logic [SEC_W-1:0] thr;
        logic             active;
    } cnt_state_t;

    cnt_state_t       st_d, st_q;
    logic [SEC_W-1:0] clamped;

    always_comb begin
        st_d    = st_q;
        clamped = SEC_W'(clamp_lease(lease_s, 32'(MAX_LEASE)));
        if (load) begin
            st_d.secs   = clamped;
            st_d.thr    = clamped >> (32'(thr_sel) + 32'd1);
            st_d.active = 1'b1;
        end else if (tick && (st_q.secs != '0)) begin
            st_d.secs = st_q.secs - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign secs   = st_q.secs;
    assign thr    = st_q.thr;
    assign active = st_q.active;

endmodule

// File: rtl/lease_timer.sv
module lease_timer
    import lease_timer_pkg::*;
#(
    parameter int CYCLES_PER_SEC = DEF_CYCLES_PER_SEC,
    parameter int MAX_LEASE      = DEF_MAX_LEASE,
    parameter int LFSR_W         = DEF_LFSR_W,
    parameter int SEC_W          = $clog2(MAX_LEASE + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [31:0]      lease_s,
    input  logic [1:0]       thr_sel,
    input  logic             stop,
    output logic             near_exp,
    output logic             expired,
    output logic [SEC_W-1:0] secs_left
);

    logic             tick;
    logic             run;
    logic [SEC_W-1:0] secs;
    logic [SEC_W-1:0] thr;
    logic             active;

    // prescaler runs only while a non-zero count is live and not stopped
    assign run = active && !stop && (secs != '0);

    lease_lfsr_prescaler #(
        .LFSR_W        (LFSR_W),
        .POLY_LOW      (LFSR_W'(27'h27)),
        .SEED          (LFSR_W'(1)),
        .CYCLES_PER_SEC(CYCLES_PER_SEC)
    ) u_pre (
        .clk    (clk),
        .rst_n  (rst_n),
        .restart(load),
        .run    (run),
        .tick   (tick)
    );

    lease_seconds_counter #(
        .MAX_LEASE(MAX_LEASE),
        .SEC_W    (SEC_W)
    ) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (load),
        .lease_s(lease_s),
        .thr_sel(thr_sel_e'(thr_sel)),
        .tick   (tick),
        .secs   (secs),
        .thr    (thr),
        .active (active)
    );

    assign secs_left = secs;
    assign expired   = active && !stop && (secs == '0);
    assign near_exp  = active && !stop && (secs <= thr);

endmodule

// File: rtl/lease_timer_chk.sv
module lease_timer_chk #(
    parameter int MAX_LEASE = 86_400,
    parameter int SEC_W     = 17
) (
    input logic             clk,
    input logic             rst_n,
    input logic             load,
    input logic [31:0]      lease_s,
    input logic             stop,
    input logic             near_exp,
    input logic             expired,
    input logic [SEC_W-1:0] secs_left
);

    // R2
    load_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (32'(secs_left) == (($past(lease_s) > 32'(MAX_LEASE)) ? 32'(MAX_LEASE) : $past(lease_s))));

    // R2
    ceiling_chk: assert property (@(posedge clk) disable iff (!rst_n)
        32'(secs_left) <= 32'(MAX_LEASE));

    // R3
    step_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> ((secs_left == $past(secs_left)) || (secs_left == $past(secs_left) - 1'b1)));

    // R4
    expired_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        expired |-> (secs_left == '0));

    // R4
    expired_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (expired && !load && !stop) |=> (expired || stop));

    // R6
    stop_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stop && !load) |=> $stable(secs_left));

    // R6
    stop_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop |-> !(near_exp || expired));

    // R5
    near_before_exp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        expired |-> near_exp);

endmodule

bind lease_timer lease_timer_chk #(
    .MAX_LEASE(MAX_LEASE),
    .SEC_W    (SEC_W)
) u_lease_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .lease_s  (lease_s),
    .stop     (stop),
    .near_exp (near_exp),
    .expired  (expired),
    .secs_left(secs_left)
);

// File: tb/tb_lease_timer.sv
module tb_lease_timer;

    localparam int P     = 20;
    localparam int MAXL  = 86_400;
    localparam int SEC_W = 17;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             load = 1'b0;
    logic [31:0]      lease_s = '0;
    logic [1:0]       thr_sel = '0;
    logic             stop = 1'b0;
    logic             near_exp;
    logic             expired;
    logic [SEC_W-1:0] secs_left;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    lease_timer #(
        .CYCLES_PER_SEC(P),
        .MAX_LEASE     (MAXL)
    ) dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .lease_s  (lease_s),
        .thr_sel  (thr_sel),
        .stop     (stop),
        .near_exp (near_exp),
        .expired  (expired),
        .secs_left(secs_left)
    );

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic edges(input int n);
        repeat (n) @(negedge clk);
    endtask

    // one load edge; returns at the negedge after it
    task automatic do_load(input int unsigned val, input int sel);
        lease_s = val;
        thr_sel = 2'(sel);
        load    = 1'b1;
        @(negedge clk);
        load    = 1'b0;
    endtask

    task automatic t_reset();
        check("R1 secs", int'(secs_left), 0);
        check("R1 near", int'(near_exp), 0);
        check("R1 expired", int'(expired), 0);
    endtask

    task automatic t_load_clamp();
        do_load(1000, 0);
        check("R2 plain", int'(secs_left), 1000);
        do_load(32'hFFFF_FFFF, 0);
        check("R2 huge clamp", int'(secs_left), MAXL);
        do_load(MAXL + 1, 0);
        check("R2 just over", int'(secs_left), MAXL);
        do_load(MAXL, 0);
        check("R2 at ceiling", int'(secs_left), MAXL);
    endtask

    task automatic t_countdown();
        do_load(5, 0);              // half threshold = 2
        edges(P - 1);
        check("R3 before first second", int'(secs_left), 5);
        edges(1);
        check("R3 first second", int'(secs_left), 4);
        edges(P);
        check("R3 second second", int'(secs_left), 3);
        edges(P - 1);
        check("R5 above half secs", int'(secs_left), 3);
        check("R5 above half near", int'(near_exp), 0);
        edges(1);
        check("R5 at half near", int'(near_exp), 1);
        edges(2 * P);
        check("R4 zero reached", int'(secs_left), 0);
        check("R4 expired", int'(expired), 1);
        edges(3 * P);
        check("R4 holds at zero", int'(secs_left), 0);
        check("R4 still expired", int'(expired), 1);
    endtask

    task automatic t_threshold();
        do_load(16, 3);             // sixteenth -> 1
        check("R5 sixteenth not near", int'(near_exp), 0);
        do_load(16, 1);             // quarter -> 4
        edges(12 * P - 1);
        check("R5 quarter secs", int'(secs_left), 5);
        check("R5 quarter not near", int'(near_exp), 0);
        edges(1);
        check("R5 quarter near", int'(near_exp), 1);
        do_load(24, 2);             // eighth -> 3
        edges(20 * P);
        check("R5 eighth not near", int'(near_exp), 0);
        edges(P);
        check("R5 eighth near", int'(near_exp), 1);
    endtask

    task automatic t_stop();
        do_load(10, 0);
        edges(10);
        stop = 1'b1;
        edges(3 * P);
        check("R6 frozen secs", int'(secs_left), 10);
        check("R6 near cleared", int'(near_exp), 0);
        stop = 1'b0;
        edges(9);
        check("R6 resume phase", int'(secs_left), 10);
        edges(1);
        check("R6 resumed drop", int'(secs_left), 9);
        do_load(0, 0);
        check("R9 zero load expired", int'(expired), 1);
        stop = 1'b1;
        edges(1);
        check("R6 expired cleared", int'(expired), 0);
        stop = 1'b0;
        edges(1);
        check("R6 expired back", int'(expired), 1);
    endtask

    task automatic t_reload();
        do_load(10, 0);
        edges(15);
        do_load(7, 0);
        edges(P - 1);
        check("R7 full second after reload", int'(secs_left), 7);
        edges(1);
        check("R7 drop after reload", int'(secs_left), 6);
    endtask

    task automatic t_coincide();
        do_load(3, 0);
        edges(P - 1);               // prescaler now at its terminal state
        do_load(8, 0);
        check("R8 load beats tick", int'(secs_left), 8);
        edges(P - 1);
        check("R8 reseeded", int'(secs_left), 8);
        edges(1);
        check("R8 next drop", int'(secs_left), 7);
    endtask

    initial begin
        edges(3);
        rst_n = 1'b1;
        edges(1);
        t_reset();
        t_load_clamp();
        t_countdown();
        t_threshold();
        t_stop();
        t_reload();
        t_coincide();
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule